// File: doc/BRIEF.md
# Occupancy-Limited Wave Issue Scheduler

This block is one vector execution lane's issue controller. It holds a pool of resident wavefronts and picks one of them to issue on each cycle. A wavefront asks to be admitted through a valid/ready handshake and states how many vector registers it needs. It is admitted only when a wave slot is free and the registers it asks for fit in what remains of the shared register file. As a result, the number of waves that can be resident at once falls as each wave's register demand rises.

Each resident wave keeps two counters of reads still in flight: one for vector memory reads and one for scalar or constant reads. Issuing a load raises the matching counter, and the wave goes on issuing in the next cycle. A wave stops only at an explicit wait instruction whose threshold is below the named counter. While it is stopped, the round-robin picker issues from the other ready waves. Read responses come back on a return port, tagged with the slot and the counter class. An end instruction retires the wave once both of its counters have drained, and the slot and registers it held can then be reused.

Instructions are supplied from outside. The block presents the chosen slot and its program counter, and the instruction word for that pair is returned in the same cycle. The instruction word has these fields: bits [1:0] hold the opcode (0 arithmetic, 1 load, 2 wait, 3 end), bit 2 holds the counter class (0 vector, 1 scalar), and bits [8:3] hold the wait threshold.

Top module: `wave_issue_sched`

## Requirements
- R1: A request for r registers (1 to 256) is accepted only if r plus the register counts of all resident waves is at most 256.
- R2: When every request is for the same count r, the number of waves that end up resident is floor(256/r) capped at 10. Counts above 128 therefore allow a single wave.
- R3: A request that does not fit keeps adm_ready low and stays pending. Once a retirement frees enough space, the request is accepted in the cycle after the retirement and the wave then issues.
- R4: An admitted wave takes the lowest-numbered free slot, which is shown on adm_slot while adm_ready is high.
- R5: Issuing a load (opcode 1) raises the counter of its class by one, and the same wave is able to issue its next instruction in the very next cycle.
- R6: A wait (opcode 2) passes when the named counter is at most the threshold. Otherwise the wave is not picked again until the counter drops to the threshold. It then reissues the wait, which passes. Other ready waves issue in the meantime.
- R7: Vector and scalar counters are separate. A wait on one class ignores the other class's outstanding reads.
- R8: Among ready waves, the pick is the first one found in slot order after the slot that issued last. After reset the search starts at slot 0.
- R9: When at least one wave is resident and none is ready, iss_valid is low and idle is high.
- R10: An end instruction (opcode 3) retires the wave only when both of its counters are zero. retire_valid pulses for one cycle, and the slot and its registers are free from the next cycle on.
- R11: Each return beat (ret_cls 0 vector, 1 scalar) lowers the matching counter of ret_slot by one.
- R12: After reset no wave is resident, iss_valid, idle and retire_valid are low, and a request for 1 register sees adm_ready high with adm_slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adm_valid | input | 1 | Admission request present |
| adm_regs | input | 9 | Vector registers the requesting wave needs |
| adm_ready | output | 1 | Request fits and is accepted when valid |
| adm_slot | output | 4 | Slot the request would occupy |
| iss_valid | output | 1 | A wave is picked this cycle |
| iss_slot | output | 4 | Picked slot |
| iss_pc | output | 8 | Program counter of the picked slot |
| iss_instr | input | 9 | Instruction word at iss_slot/iss_pc |
| idle | output | 1 | Waves resident but none ready |
| retire_valid | output | 1 | The picked wave retires this cycle |
| ret_valid | input | 1 | Read response beat |
| ret_slot | input | 4 | Slot the response belongs to |
| ret_cls | input | 1 | Counter class of the response |

## Verification
The hardest situation to reach from the ports is a request that is held back while a register-heavy wave sits on an end instruction with reads still in flight. Admission must stay closed through the stall and through the retiring cycle itself, and must open exactly one cycle later. The bench builds this by admitting a 256-register wave whose program is a load followed by an end. It then keeps a 1-register request pending and holds the read response back until the idle cycle. A full sweep of uniform register counts from 1 to 256 checks the occupancy formula and the order in which slots are assigned.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_LOAD = 2'd1,
    OP_WAIT = 2'd2,
    OP_END  = 2'd3
  } op_e;

  // bits [1:0] opcode, bit 2 counter class, upper bits wait threshold
  typedef struct packed {
    logic [CNT_W-1:0] thr;
    logic             cls;
    op_e              op;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/wis_admit.sv
module wis_admit #(
  parameter int N      = 10,
  parameter int BUDGET = 256,
  parameter int REG_W  = 9,
  localparam int SW    = (N > 1) ? $clog2(N) : 1,
  localparam int USE_W = REG_W + SW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              resident,
  input  logic [N-1:0][REG_W-1:0]   regs_held,
  input  logic                      adm_valid,
  input  logic [REG_W-1:0]          adm_regs,
  output logic                      adm_ready,
  output logic [SW-1:0]             adm_slot,
  output logic [N-1:0]              alloc
);
  logic [USE_W-1:0] used;
  logic [USE_W-1:0] total;
  logic             free_ok;
  logic [SW-1:0]    free_idx;
  logic             fits;

  always_comb begin
    used     = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (resident[i]) used = used + USE_W'(regs_held[i]);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!resident[i]) begin
        free_ok  = 1'b1;
        free_idx = SW'(i);
      end
    end
    total     = used + USE_W'(adm_regs);
    fits      = (total <= USE_W'(BUDGET));
    adm_ready = free_ok & fits;
    adm_slot  = free_idx;
    alloc     = (adm_valid && adm_ready) ? (N'(1) << free_idx) : '0;
  end

  // R1: resident register demand never exceeds the register file
  a_r1_budget_kept: assert property (@(posedge clk) disable iff (!rst_n)
    used <= USE_W'(BUDGET));
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N  = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_valid
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] last_d;
  logic [IW-1:0] ci;
  logic [IW-1:0] after_last;
  int            cand;

  always_comb begin
    gnt       = '0;
    gnt_idx   = '0;
    gnt_valid = 1'b0;
    ci        = '0;
    cand      = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      ci   = IW'(cand);
      if (!gnt_valid && req[ci]) begin
        gnt_valid = 1'b1;
        gnt_idx   = ci;
        gnt[ci]   = 1'b1;
      end
    end
    last_d     = gnt_valid ? gnt_idx : last_q;
    after_last = (last_q == IW'(N - 1)) ? '0 : last_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= IW'(N - 1);
    else if (gnt_valid) last_q <= last_d;
  end

  // R8: a single grant per cycle
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R8: the slot right after the last issuer wins when it is ready
  a_r8_rr_next: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && req[after_last]) |-> (gnt_idx == after_last));
endmodule

// File: rtl/wis_slot.sv
module wis_slot import wis_pkg::*; #(
  parameter int REG_W = 9,
  parameter int PC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [REG_W-1:0] regs_i,
  input  logic             pick_i,
  input  instr_t           instr_i,
  input  logic             ret_v_i,
  input  logic             ret_s_i,
  output logic             resident_o,
  output logic             ready_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [REG_W-1:0] regs_o,
  output logic             retire_o
);
  logic             resident_q, resident_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [REG_W-1:0] regs_q, regs_d;
  logic [CNT_W-1:0] cnt_v_q, cnt_v_d, cnt_s_q, cnt_s_d;
  logic             wait_q, wait_d;
  logic [1:0]       wmask_q, wmask_d;
  logic [CNT_W-1:0] wthr_q, wthr_d;
  logic             cond_stored, icond, advance, blocked, inc_v, inc_s, en;
  logic [1:0]       imask;
  logic [CNT_W-1:0] ithr;

  always_comb begin
    cond_stored = (!wmask_q[0] || cnt_v_q <= wthr_q) && (!wmask_q[1] || cnt_s_q <= wthr_q);
    ready_o     = resident_q && (!wait_q || cond_stored);
    case (instr_i.op)
      OP_END:  imask = 2'b11;
      OP_WAIT: imask = instr_i.cls ? 2'b10 : 2'b01;
      default: imask = 2'b00;
    endcase
    ithr     = (instr_i.op == OP_END) ? '0 : instr_i.thr;
    icond    = (!imask[0] || cnt_v_q <= ithr) && (!imask[1] || cnt_s_q <= ithr);
    advance  = pick_i && icond;
    blocked  = pick_i && !icond;
    inc_v    = pick_i && (instr_i.op == OP_LOAD) && !instr_i.cls;
    inc_s    = pick_i && (instr_i.op == OP_LOAD) && instr_i.cls;
    retire_o = advance && (instr_i.op == OP_END);

    resident_d = resident_q;
    pc_d       = pc_q;
    regs_d     = regs_q;
    wait_d     = wait_q;
    wmask_d    = wmask_q;
    wthr_d     = wthr_q;
    cnt_v_d    = cnt_v_q + CNT_W'(inc_v) - CNT_W'(ret_v_i);
    cnt_s_d    = cnt_s_q + CNT_W'(inc_s) - CNT_W'(ret_s_i);
    if (advance) pc_d = pc_q + PC_W'(1);
    if (pick_i)  wait_d = blocked;
    if (blocked) begin
      wmask_d = imask;
      wthr_d  = ithr;
    end
    if (retire_o) resident_d = 1'b0;
    if (alloc_i) begin
      resident_d = 1'b1;
      pc_d       = '0;
      regs_d     = regs_i;
      wait_d     = 1'b0;
    end
    en = alloc_i || pick_i || ret_v_i || ret_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resident_q <= 1'b0;
      pc_q       <= '0;
      regs_q     <= '0;
      cnt_v_q    <= '0;
      cnt_s_q    <= '0;
      wait_q     <= 1'b0;
      wmask_q    <= '0;
      wthr_q     <= '0;
    end else if (en) begin
      resident_q <= resident_d;
      pc_q       <= pc_d;
      regs_q     <= regs_d;
      cnt_v_q    <= cnt_v_d;
      cnt_s_q    <= cnt_s_d;
      wait_q     <= wait_d;
      wmask_q    <= wmask_d;
      wthr_q     <= wthr_d;
    end
  end

  assign resident_o = resident_q;
  assign pc_o       = pc_q;
  assign regs_o     = regs_q;

  // R5: a load never holds the wave back
  a_r5_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_i && instr_i.op == OP_LOAD) |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R6: a wave blocked on its wait is never picked
  a_r6_blocked_unpicked: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !cond_stored) |-> !pick_i);
  // R10: retirement empties the slot
  a_r10_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |=> !resident_o);
  // R11: responses only arrive for reads in flight
  a_r11_vec_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ret_v_i |-> (cnt_v_q != '0));
  a_r11_sca_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ret_s_i |-> (cnt_s_q != '0));
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched import wis_pkg::*; #(
  parameter int NUM_SLOTS  = 10,
  parameter int REG_BUDGET = 256,
  parameter int PC_W       = 8,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int REG_W     = $clog2(REG_BUDGET + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adm_valid,
  input  logic [REG_W-1:0]   adm_regs,
  output logic               adm_ready,
  output logic [SLOT_W-1:0]  adm_slot,
  output logic               iss_valid,
  output logic [SLOT_W-1:0]  iss_slot,
  output logic [PC_W-1:0]    iss_pc,
  input  logic [INSTR_W-1:0] iss_instr,
  output logic               idle,
  output logic               retire_valid,
  input  logic               ret_valid,
  input  logic [SLOT_W-1:0]  ret_slot,
  input  logic               ret_cls
);
  logic [NUM_SLOTS-1:0]             resident, ready, alloc, pick, retire;
  logic [NUM_SLOTS-1:0][REG_W-1:0]  regs_held;
  logic [NUM_SLOTS-1:0][PC_W-1:0]   pc_arr;
  instr_t                           cur_instr;

  assign cur_instr = iss_instr;

  wis_admit #(.N(NUM_SLOTS), .BUDGET(REG_BUDGET), .REG_W(REG_W)) u_admit (
    .clk(clk), .rst_n(rst_n), .resident(resident), .regs_held(regs_held),
    .adm_valid(adm_valid), .adm_regs(adm_regs), .adm_ready(adm_ready),
    .adm_slot(adm_slot), .alloc(alloc)
  );

  wis_rr_pick #(.N(NUM_SLOTS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(ready), .gnt(pick),
    .gnt_idx(iss_slot), .gnt_valid(iss_valid)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    wis_slot #(.REG_W(REG_W), .PC_W(PC_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc[g]), .regs_i(adm_regs),
      .pick_i(pick[g]), .instr_i(cur_instr),
      .ret_v_i(ret_valid && ret_slot == SLOT_W'(g) && !ret_cls),
      .ret_s_i(ret_valid && ret_slot == SLOT_W'(g) && ret_cls),
      .resident_o(resident[g]), .ready_o(ready[g]), .pc_o(pc_arr[g]),
      .regs_o(regs_held[g]), .retire_o(retire[g])
    );
  end

  assign iss_pc       = pc_arr[iss_slot];
  assign retire_valid = |retire;
  assign idle         = (|resident) && !iss_valid;
endmodule

// File: tb/wave_issue_sched_test.sv
module wave_issue_sched_test;
  import wis_pkg::*;
  localparam int SW = 4;
  localparam int RW = 9;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, adm_valid, adm_ready, iss_valid, idle, retire_valid;
  logic ret_valid, ret_cls;
  logic [RW-1:0] adm_regs;
  logic [SW-1:0] adm_slot, iss_slot, ret_slot;
  logic [PW-1:0] iss_pc;
  logic [INSTR_W-1:0] iss_instr;
  logic [INSTR_W-1:0] prog [16][16];

  int n_cmp = 0;
  int n_bad = 0;

  assign iss_instr = prog[iss_slot][iss_pc[3:0]];

  wave_issue_sched uut (
    .clk(clk), .rst_n(rst_n), .adm_valid(adm_valid), .adm_regs(adm_regs),
    .adm_ready(adm_ready), .adm_slot(adm_slot), .iss_valid(iss_valid),
    .iss_slot(iss_slot), .iss_pc(iss_pc), .iss_instr(iss_instr), .idle(idle),
    .retire_valid(retire_valid), .ret_valid(ret_valid), .ret_slot(ret_slot),
    .ret_cls(ret_cls)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [INSTR_W-1:0] mk(input op_e op, input logic cls, input int thr);
    logic [CNT_W-1:0] t;
    t = CNT_W'(thr);
    return {t, cls, op};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) prog[i][j] = mk(OP_ALU, 1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; adm_valid = 1'b0; adm_regs = 9'd1;
    ret_valid = 1'b0; ret_slot = '0; ret_cls = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic admit_one(input int regs);
    @(negedge clk);
    adm_valid = 1'b1; adm_regs = RW'(regs);
    #1 chk("R1 single admission accepted", int'(adm_ready), 1);
    @(negedge clk);
    adm_valid = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic give_ret(input int slot, input logic cls);
    ret_valid = 1'b1; ret_slot = SW'(slot); ret_cls = cls;
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    int expv;
    rst_n = 1'b0; adm_valid = 1'b0; adm_regs = 9'd1;
    ret_valid = 1'b0; ret_slot = '0; ret_cls = 1'b0;
    clear_prog();

    // R12 reset state
    do_reset();
    #1;
    chk("R12 iss_valid after reset", int'(iss_valid), 0);
    chk("R12 idle after reset", int'(idle), 0);
    chk("R12 retire_valid after reset", int'(retire_valid), 0);
    chk("R12 adm_ready after reset", int'(adm_ready), 1);
    chk("R12 adm_slot after reset", int'(adm_slot), 0);

    // R1/R2/R4 uniform sweep over every register count
    for (int r = 1; r <= 256; r++) begin
      do_reset();
      adm_valid = 1'b1; adm_regs = RW'(r);
      cnt = 0;
      for (int c = 0; c < 12; c++) begin
        #1;
        if (adm_ready) begin
          chk("R4 lowest free slot", int'(adm_slot), cnt);
          cnt++;
        end
        @(negedge clk);
      end
      adm_valid = 1'b0;
      expv = (256 / r < 10) ? 256 / r : 10;
      chk($sformatf("R2 R1 resident waves at %0d regs", r), cnt, expv);
    end

    // R1 mixed demand: 200 resident, 57 refused, 56 accepted
    do_reset();
    admit_one(200);
    adm_regs = 9'd57; adm_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1 chk("R1 over-budget request refused", int'(adm_ready), 0);
      @(negedge clk);
    end
    adm_regs = 9'd56;
    #1 chk("R1 exact-fit request accepted", int'(adm_ready), 1);
    chk("R4 second slot", int'(adm_slot), 1);
    @(negedge clk);
    adm_valid = 1'b0;

    // R5 R6 R9 R10 R11: load, two arithmetic, wait vec 0, end
    clear_prog();
    prog[0][0] = mk(OP_LOAD, 1'b0, 0);
    prog[0][3] = mk(OP_WAIT, 1'b0, 0);
    prog[0][4] = mk(OP_END, 1'b0, 0);
    do_reset();
    admit_one(32);
    for (int k = 0; k < 4; k++) begin
      chk("R5 issue continues after load valid", int'(iss_valid), 1);
      chk("R5 issue continues after load pc", int'(iss_pc), k);
      step();
    end
    chk("R6 wait stalls wave", int'(iss_valid), 0);
    chk("R9 idle while stalled", int'(idle), 1);
    give_ret(0, 1'b0);
    chk("R11 return releases wait", int'(iss_valid), 1);
    chk("R6 wait reissued pc", int'(iss_pc), 3);
    step();
    chk("R10 end reached pc", int'(iss_pc), 4);
    chk("R10 retire with drained counters", int'(retire_valid), 1);
    step();
    chk("R10 slot empty after retire", int'(iss_valid), 0);
    chk("R9 no idle when nothing resident", int'(idle), 0);
    adm_regs = 9'd256;
    #1 chk("R10 registers freed", int'(adm_ready), 1);

    // R6 threshold above zero: two loads, wait vec 1, end
    clear_prog();
    prog[0][0] = mk(OP_LOAD, 1'b0, 0);
    prog[0][1] = mk(OP_LOAD, 1'b0, 0);
    prog[0][2] = mk(OP_WAIT, 1'b0, 1);
    prog[0][3] = mk(OP_END, 1'b0, 0);
    do_reset();
    admit_one(8);
    for (int k = 0; k < 3; k++) begin
      chk("R5 back-to-back loads pc", int'(iss_pc), k);
      step();
    end
    chk("R6 two in flight exceeds threshold 1", int'(iss_valid), 0);
    give_ret(0, 1'b0);
    chk("R6 one in flight meets threshold 1", int'(iss_valid), 1);
    chk("R6 wait reissued at pc 2", int'(iss_pc), 2);
    step();
    chk("R10 end seen", int'(iss_pc), 3);
    chk("R10 no retire with read in flight", int'(retire_valid), 0);
    step();
    chk("R9 idle on blocked end", int'(idle), 1);
    give_ret(0, 1'b0);
    chk("R10 retire after drain", int'(retire_valid), 1);

    // R7 separate classes: scalar load, wait vec 0, wait scalar 0, end
    clear_prog();
    prog[0][0] = mk(OP_LOAD, 1'b1, 0);
    prog[0][1] = mk(OP_WAIT, 1'b0, 0);
    prog[0][2] = mk(OP_WAIT, 1'b1, 0);
    prog[0][3] = mk(OP_END, 1'b0, 0);
    do_reset();
    admit_one(16);
    step();
    chk("R7 vector wait ignores scalar read", int'(iss_pc), 1);
    step();
    chk("R7 scalar wait issued", int'(iss_pc), 2);
    step();
    chk("R7 scalar wait stalls", int'(iss_valid), 0);
    give_ret(0, 1'b1);
    chk("R11 scalar return releases", int'(iss_pc), 2);
    step();
    chk("R7 retire after scalar drain", int'(retire_valid), 1);

    // R6 R8 switching: slot 0 load+wait, slot 1 arithmetic only
    clear_prog();
    prog[0][0] = mk(OP_LOAD, 1'b0, 0);
    prog[0][1] = mk(OP_WAIT, 1'b0, 0);
    prog[0][2] = mk(OP_END, 1'b0, 0);
    do_reset();
    @(negedge clk);
    adm_valid = 1'b1; adm_regs = 9'd64;
    #1 chk("R1 first 64", int'(adm_ready), 1);
    step();
    chk("R4 second wave slot", int'(adm_slot), 1);
    chk("R8 only slot 0 ready", int'(iss_slot), 0);
    @(negedge clk);
    adm_valid = 1'b0;
    #1 chk("R8 rotation to slot 1", int'(iss_slot), 1);
    step();
    chk("R8 rotation back to slot 0", int'(iss_slot), 0);
    chk("R6 slot 0 at its wait", int'(iss_pc), 1);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R6 other wave issues during stall valid", int'(iss_valid), 1);
      chk("R6 other wave issues during stall slot", int'(iss_slot), 1);
    end
    give_ret(0, 1'b0);
    chk("R6 stalled wave resumes", int'(iss_slot), 0);
    chk("R6 resumes at its wait", int'(iss_pc), 1);

    // R8 three always-ready waves rotate in slot order
    clear_prog();
    do_reset();
    @(negedge clk);
    adm_valid = 1'b1; adm_regs = 9'd10;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    adm_valid = 1'b0;
    #1;
    expv = 2;
    for (int k = 0; k < 9; k++) begin
      chk("R8 round-robin order", int'(iss_slot), expv);
      expv = (expv + 1) % 3;
      step();
    end

    // R3 R10 held request: 256-register wave with load then end
    clear_prog();
    prog[0][0] = mk(OP_LOAD, 1'b0, 0);
    prog[0][1] = mk(OP_END, 1'b0, 0);
    do_reset();
    admit_one(256);
    adm_valid = 1'b1; adm_regs = 9'd1;
    #1 chk("R3 request held while full", int'(adm_ready), 0);
    step();
    chk("R3 held at blocked end", int'(adm_ready), 0);
    step();
    chk("R3 held during idle", int'(adm_ready), 0);
    chk("R9 idle on end with read in flight", int'(idle), 1);
    give_ret(0, 1'b0);
    chk("R10 retire pulse", int'(retire_valid), 1);
    chk("R3 still held in retire cycle", int'(adm_ready), 0);
    step();
    chk("R3 accepted cycle after retire", int'(adm_ready), 1);
    chk("R3 freed slot reused", int'(adm_slot), 0);
    @(negedge clk);
    adm_valid = 1'b0;
    #1 chk("R3 pending wave admitted and issuing", int'(iss_valid), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule